// File: doc/BRIEF.md
# Half-Word Masked GPIO Register Port

This block holds the control state of a 32-pin general-purpose I/O bank behind a simple memory-mapped bus. Every 32-bit logical register is reached as two bus words: the low word carries logical bits 0 to 15, and the word four bytes above it carries bits 16 to 31. A write to either word sends a 16-bit enable mask in the upper half of the bus data and 16 new values in the lower half. Only the bits whose enable is set take the new value, so software can set or clear one pin with a single write and no read-modify-write.

The block keeps an output-value register and an output-enable register, and drives both straight onto the pad side. Pin levels come in through a two-flop synchronizer and are read back as one plain 32-bit word. A fixed identification word can also be read. Bus accesses go through a small state machine with two states. `ST_IDLE` waits for a request. On the transition *accept* (select high) it performs any write and captures the read data, then moves to `ST_ACK`. `ST_ACK` raises the acknowledge for one cycle and takes the transition *release* back to `ST_IDLE` without condition.

Top module: `gpio_hwport`

## Requirements
- R1: After reset, pin_out and pin_oe are all zeros, so every pin starts as an input, and bus_ack is low.
- R2: A write to a half-word location updates stored bit i (i in 0..15) to bus_wdata[i] only when bus_wdata[16+i] is 1. Bits whose enable is 0 keep their value.
- R3: The word at a register's base offset holds logical bits 15:0. The word at base+4 holds logical bits 31:16, using the same mask-plus-value format.
- R4: A read of a half-word location returns the 16 stored bits in bus_rdata[15:0] and zeros in bus_rdata[31:16].
- R5: The output-value register sits at 0x00/0x04 and drives pin_out. The output-enable register sits at 0x08/0x0C and drives pin_oe, where a 1 makes the pin an output and a 0 makes it an input.
- R6: A read of 0x78 returns the constant 0x01000C2B.
- R7: A read of 0x70 returns all 32 pin_in levels as one word after a two-stage synchronizer. A pin change driven just before the clock edge that precedes an accept edge is not yet visible in that read. It is visible once three edges have passed.
- R8: Writes to 0x70, 0x78 or any unmapped address change no register. Reads of unmapped addresses return 0.
- R9: A request seen in ST_IDLE is acknowledged in the very next cycle. bus_ack stays high for exactly one cycle and is never raised without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Request; held until bus_ack is seen |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the word |
| bus_wdata | input | 32 | Write data: [31:16] enable mask, [15:0] values |
| bus_ack | output | 1 | One-cycle acknowledge; bus_rdata is valid with it |
| bus_rdata | output | 32 | Read data |
| pin_in | input | 32 | Pin levels from the pads (asynchronous) |
| pin_out | output | 32 | Output values to the pads |
| pin_oe | output | 32 | Output enables to the pads (1 = drive) |

## Verification
Some properties are checked by assertions on every cycle:
- A register that receives no write strobe keeps its value, and a write to one half never disturbs the other half.
- The acknowledge is a single-cycle pulse that follows an accepted request and never appears on its own.
- The synchronizer output equals the pin levels from two edges earlier.

Other behaviour can only be shown by the bench scenarios:
- Masked writes that set some bits and clear others.
- The address map and the placement of the high half.
- The fixed identification word, and the zero upper half on half-word reads.
- The one-edge lag of a fresh pin change in an external-port read.
- Writes to read-only or unmapped addresses leaving the pads untouched.

// File: rtl/gpio_hwport_pkg.sv
package gpio_hwport_pkg;

    localparam int ADDR_W  = 8;
    localparam int LOGIC_W = 32;
    localparam int HALF_W  = LOGIC_W / 2;

    localparam logic [ADDR_W-1:0] A_OUT_LO = 8'h00;
    localparam logic [ADDR_W-1:0] A_OUT_HI = 8'h04;
    localparam logic [ADDR_W-1:0] A_DIR_LO = 8'h08;
    localparam logic [ADDR_W-1:0] A_DIR_HI = 8'h0C;
    localparam logic [ADDR_W-1:0] A_EXT    = 8'h70;
    localparam logic [ADDR_W-1:0] A_ID     = 8'h78;

    localparam logic [LOGIC_W-1:0] ID_WORD = 32'h01000C2B;

    typedef enum logic {
        ST_IDLE,
        ST_ACK
    } bus_state_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_OUT_LO,
        TGT_OUT_HI,
        TGT_DIR_LO,
        TGT_DIR_HI,
        TGT_EXT,
        TGT_ID
    } target_e;

    function automatic target_e decode_addr(input logic [ADDR_W-1:0] a);
        target_e t;
        unique case (a)
            A_OUT_LO: t = TGT_OUT_LO;
            A_OUT_HI: t = TGT_OUT_HI;
            A_DIR_LO: t = TGT_DIR_LO;
            A_DIR_HI: t = TGT_DIR_HI;
            A_EXT:    t = TGT_EXT;
            A_ID:     t = TGT_ID;
            default:  t = TGT_NONE;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/gpio_halfword_reg.sv
module gpio_halfword_reg #(
    parameter int LOGIC_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [LOGIC_W-1:0] wdata,
    output logic [LOGIC_W-1:0] q
);
    localparam int HALF_W = LOGIC_W / 2;

    logic [1:0] wr_half;
    assign wr_half = {wr_hi, wr_lo};

    for (genvar h = 0; h < 2; h++) begin : g_half
        for (genvar b = 0; b < HALF_W; b++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q[h*HALF_W + b] <= 1'b0;
                end else if (wr_half[h] && wdata[HALF_W + b]) begin
                    q[h*HALF_W + b] <= wdata[b];
                end
            end
        end
    end

    // R2: no strobe, no change
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo && !wr_hi) |=> $stable(q));

    // R3: a high-half write leaves the low half alone
    p_lo_untouched_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_lo) |=> $stable(q[HALF_W-1:0]));

    // R3: a low-half write leaves the high half alone
    p_hi_untouched_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wr_hi) |=> $stable(q[LOGIC_W-1:HALF_W]));

    // R2: an all-zero mask changes nothing
    p_zero_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wdata[LOGIC_W-1:HALF_W] == '0) |=> $stable(q));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else if (s == 0) begin
                stage_q[s] <= d;
            end else begin
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

    // Warm-up counter so the latency check never looks before reset
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    // R7: two-edge latency from pad to synchronized level
    p_sync_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3) |-> (q == $past(d, 2)));

endmodule

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_hwport_pkg::*;
#(
    parameter int LOGIC_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [LOGIC_W-1:0] out_q,
    input  logic [LOGIC_W-1:0] dir_q,
    input  logic [LOGIC_W-1:0] ext_q,
    output logic               wr_out_lo,
    output logic               wr_out_hi,
    output logic               wr_dir_lo,
    output logic               wr_dir_hi,
    output logic               bus_ack,
    output logic [LOGIC_W-1:0] bus_rdata
);
    localparam int H = LOGIC_W / 2;

    bus_state_e         state_q, state_nx;
    target_e            tgt;
    logic               accept;
    logic [LOGIC_W-1:0] rd_mux;
    logic [LOGIC_W-1:0] rdata_q;

    assign tgt    = decode_addr(bus_addr);
    assign accept = (state_q == ST_IDLE) && bus_sel;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Transitions: accept (IDLE->ACK), release (ACK->IDLE)
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (bus_sel) state_nx = ST_ACK;
            ST_ACK:  state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        wr_out_lo = 1'b0;
        wr_out_hi = 1'b0;
        wr_dir_lo = 1'b0;
        wr_dir_hi = 1'b0;
        if (accept && bus_wr) begin
            unique case (tgt)
                TGT_OUT_LO: wr_out_lo = 1'b1;
                TGT_OUT_HI: wr_out_hi = 1'b1;
                TGT_DIR_LO: wr_dir_lo = 1'b1;
                TGT_DIR_HI: wr_dir_hi = 1'b1;
                default: ;
            endcase
        end
        unique case (tgt)
            TGT_OUT_LO: rd_mux = {{H{1'b0}}, out_q[H-1:0]};
            TGT_OUT_HI: rd_mux = {{H{1'b0}}, out_q[LOGIC_W-1:H]};
            TGT_DIR_LO: rd_mux = {{H{1'b0}}, dir_q[H-1:0]};
            TGT_DIR_HI: rd_mux = {{H{1'b0}}, dir_q[LOGIC_W-1:H]};
            TGT_EXT:    rd_mux = ext_q;
            TGT_ID:     rd_mux = ID_WORD;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (accept) rdata_q <= bus_wr ? '0 : rd_mux;
    end

    assign bus_ack   = (state_q == ST_ACK);
    assign bus_rdata = rdata_q;

    // R9: acknowledge is a one-cycle pulse
    p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    // R9: an accepted request is acknowledged next cycle
    p_ack_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_ack && bus_sel) |=> bus_ack);

    // R9: no acknowledge without a request
    p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sel) |=> !bus_ack);

    // R9: at most one write strobe per cycle
    p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_out_lo, wr_out_hi, wr_dir_lo, wr_dir_hi}));

endmodule

// File: rtl/gpio_hwport.sv
module gpio_hwport
    import gpio_hwport_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [LOGIC_W-1:0] bus_wdata,
    output logic               bus_ack,
    output logic [LOGIC_W-1:0] bus_rdata,
    input  logic [LOGIC_W-1:0] pin_in,
    output logic [LOGIC_W-1:0] pin_out,
    output logic [LOGIC_W-1:0] pin_oe
);
    logic wr_out_lo, wr_out_hi, wr_dir_lo, wr_dir_hi;
    logic [LOGIC_W-1:0] out_q, dir_q, ext_q;

    gpio_in_sync #(.WIDTH(LOGIC_W), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(ext_q)
    );

    gpio_halfword_reg #(.LOGIC_W(LOGIC_W)) u_out_reg (
        .clk(clk), .rst_n(rst_n), .wr_lo(wr_out_lo), .wr_hi(wr_out_hi),
        .wdata(bus_wdata), .q(out_q)
    );

    gpio_halfword_reg #(.LOGIC_W(LOGIC_W)) u_dir_reg (
        .clk(clk), .rst_n(rst_n), .wr_lo(wr_dir_lo), .wr_hi(wr_dir_hi),
        .wdata(bus_wdata), .q(dir_q)
    );

    gpio_bus_fsm #(.LOGIC_W(LOGIC_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .out_q(out_q), .dir_q(dir_q), .ext_q(ext_q),
        .wr_out_lo(wr_out_lo), .wr_out_hi(wr_out_hi),
        .wr_dir_lo(wr_dir_lo), .wr_dir_hi(wr_dir_hi),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    assign pin_out = out_q;
    assign pin_oe  = dir_q;

    // R5: pad outputs only move on an acknowledged write cycle
    p_pads_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr && !bus_ack) |=> ($stable(pin_out) && $stable(pin_oe)));

endmodule

// File: tb/tb_gpio_hwport.sv
`timescale 1ns/1ps
module tb_gpio_hwport;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ack;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [31:0] exp_q [$];
    bit          chk_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    gpio_hwport dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected item per acknowledge
    always @(negedge clk) begin
        if (rst_n && bus_ack) begin
            if (exp_q.size() == 0) begin
                check("R9 unexpected ack", 32'd1, 32'd0);
            end else begin
                logic [31:0] e;
                bit c;
                string t;
                e = exp_q.pop_front();
                c = chk_q.pop_front();
                t = tag_q.pop_front();
                if (c) check(t, bus_rdata, e);
            end
        end
    end

    // Driver: pushes the expectation, issues the request, waits for ack
    task automatic access(input bit wr, input logic [7:0] a, input logic [31:0] d,
                          input logic [31:0] exp, input string tag);
        int n;
        @(negedge clk);
        exp_q.push_back(exp);
        chk_q.push_back(!wr);
        tag_q.push_back(tag);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!bus_ack && n < 8);
        bus_sel = 1'b0; bus_wr = 1'b0;
        check("R9 ack latency", n, 1);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        access(1'b1, a, d, 32'h0, "write");
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        access(1'b0, a, 32'h0, exp, tag);
    endtask

    initial begin
        #20000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 pin_out after reset", pin_out, 32'h0);
        check("R1 pin_oe after reset", pin_oe, 32'h0);
        check("R1 ack after reset", {31'h0, bus_ack}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 no ack while idle", {31'h0, bus_ack}, 32'h0);

        // R2/R4: set bits 0 and 2, then clear bit 0 alone
        wr(8'h00, 32'h0005_0005);
        rd(8'h00, 32'h0000_0005, "R4 out lo readback");
        wr(8'h00, 32'h0001_0000);
        rd(8'h00, 32'h0000_0004, "R2 masked clear keeps bit2");
        check("R5 pin_out low", pin_out, 32'h0000_0004);

        // R3: high half at +4
        wr(8'h04, 32'hFFFF_A5A5);
        rd(8'h04, 32'h0000_A5A5, "R3 out hi readback");
        rd(8'h00, 32'h0000_0004, "R3 low half untouched");
        check("R3 pin_out full", pin_out, 32'hA5A5_0004);

        // R5: direction register
        wr(8'h08, 32'h00FF_00F0);
        wr(8'h0C, 32'h8000_8000);
        check("R5 pin_oe", pin_oe, 32'h8000_00F0);
        rd(8'h08, 32'h0000_00F0, "R5 dir lo readback");
        rd(8'h0C, 32'h0000_8000, "R5 dir hi readback");

        // R2: zero mask does nothing; partial mask on high half
        wr(8'h00, 32'h0000_FFFF);
        rd(8'h00, 32'h0000_0004, "R2 zero mask no change");
        wr(8'h04, 32'h00F0_0000);
        check("R2 partial mask high half", pin_out, 32'hA505_0004);

        // R6: identification word
        rd(8'h78, 32'h0100_0C2B, "R6 id word");

        // R7: synchronizer lag, then settled value
        @(negedge clk);
        pin_in = 32'h1234_5678;
        rd(8'h70, 32'h0000_0000, "R7 fresh change not yet visible");
        repeat (3) @(negedge clk);
        rd(8'h70, 32'h1234_5678, "R7 ext port settled");
        pin_in = 32'hFFFF_0000;
        repeat (4) @(negedge clk);
        rd(8'h70, 32'hFFFF_0000, "R7 ext port second pattern");

        // R8: read-only and unmapped writes ignored
        wr(8'h70, 32'hFFFF_FFFF);
        wr(8'h78, 32'hFFFF_FFFF);
        wr(8'h40, 32'hFFFF_FFFF);
        check("R8 pin_out after ignored writes", pin_out, 32'hA505_0004);
        check("R8 pin_oe after ignored writes", pin_oe, 32'h8000_00F0);
        rd(8'h78, 32'h0100_0C2B, "R8 id unchanged");
        rd(8'h70, 32'hFFFF_0000, "R8 ext unchanged");
        rd(8'h40, 32'h0000_0000, "R8 unmapped read zero");
        rd(8'h00, 32'h0000_0004, "R8 out lo unchanged");

        repeat (3) @(negedge clk);
        check("R9 queue drained", exp_q.size(), 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule